// File: doc/BRIEF.md
# T1 Framing Bit Error Checker

This block watches the framing bit of every 193-bit T1 frame once frame alignment has been acquired and reports each framing bit that does not carry its expected value. An upstream aligner presents the framing bit with a strobe, the frame's position within the current superframe or extended superframe, and a flag that says whether alignment is held. The block decides whether that position is one it checks in the selected framing format, compares the bit against the expected pattern, and emits a registered single-cycle error pulse.

The checked positions depend on the format. In extended superframe operation only the six frame-pattern positions are checked. In the 72-frame subscriber-carrier format only the terminal framing bits are checked. In the 12-frame superframe format the terminal framing bits are always checked and the signaling framing bits are checked on request, except the one in the last frame. The error pulse drives an internal wrapping 8-bit error counter. It also drives two interrupt pulses, each with its own enable: one fires on every error and one fires when the counter rolls over.

Top module: `t1_fbit_checker`

## Requirements
- R1: After reset the error pulse, both interrupt pulses and the error count are all zero.
- R2: With mode = 0 (extended superframe), only frame indices 3, 7, 11, 15, 19 and 23 are checked, against the expected bits 0, 0, 1, 0, 1, 1 in that order. A framing bit at any other index never causes an error.
- R3: With mode = 1 (12-frame superframe), the terminal framing bits at even indices 0 to 10 are always checked. Their expected value is 1 when (index/2) is even and 0 otherwise.
- R4: With mode = 1, the signaling framing bits at odd indices 1, 3, 5, 7 and 9 are checked against 0, 0, 1, 1, 1 only while fs_chk_en is 1. Index 11 is never checked.
- R5: With mode = 2 (72-frame subscriber-carrier format), the bits at even indices 0 to 70 are checked against 1 when (index/2) is even and 0 otherwise. Odd indices are never checked.
- R6: err_pulse is high for exactly one clock, in the cycle after a clock edge that samples fbit_vld = 1 with in_sync = 1 and a checked mismatching bit. Nothing is flagged while fbit_vld or in_sync is low.
- R7: Mode 3, and any frame index at or beyond the length of the selected format's frame sequence, produce no error.
- R8: err_cnt goes up by one in the same cycle as each err_pulse and wraps from 255 to 0. The wrap also raises ovf_irq for that one cycle when ovf_irq_en is set.
- R9: While cnt_clr is high the count is forced to zero and no overflow interrupt occurs. Error pulses are still reported.
- R10: evt_irq goes high together with each err_pulse only when evt_irq_en was set. ovf_irq goes high only when ovf_irq_en was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Framing format: 0 ESF, 1 superframe, 2 subscriber-carrier, 3 none |
| fs_chk_en | input | 1 | Enables the signaling framing bit check in superframe mode |
| in_sync | input | 1 | Frame alignment is held |
| fbit_vld | input | 1 | Strobe: fbit and frame_idx are valid this cycle |
| fbit | input | 1 | Received framing bit |
| frame_idx | input | 7 | Zero-based frame position within the multiframe |
| cnt_clr | input | 1 | Clears the error counter and holds it at zero |
| evt_irq_en | input | 1 | Enables the per-error interrupt |
| ovf_irq_en | input | 1 | Enables the counter rollover interrupt |
| err_pulse | output | 1 | One-cycle framing bit error indication |
| err_cnt | output | 8 | Framing error count |
| evt_irq | output | 1 | Per-error interrupt pulse |
| ovf_irq | output | 1 | Counter rollover interrupt pulse |

## Verification
On every cycle, the assertions check the timing and gating rules. An error pulse must follow a valid, aligned strobe. Interrupts must follow their enables. The count must step by exactly one per pulse and hold otherwise, and it must be zero after a clear. A rollover must coincide with a zero count. They also check that unchecked positions (mode 3, and the non-pattern ESF frames) never yield a pulse. Only the bench's scenarios can show that the expected bit patterns are right for each format and index. The same goes for the optional check of the signaling bits, the exclusion of the last superframe frame, and the exact 256-error rollover point.

// File: rtl/t1fc_pkg.sv
package t1fc_pkg;

  typedef enum logic [1:0] {
    FM_ESF  = 2'd0,
    FM_SF   = 2'd1,
    FM_SLC  = 2'd2,
    FM_NONE = 2'd3
  } fmode_e;

  localparam int ESF_FRAMES = 24;
  localparam int SF_FRAMES  = 12;
  localparam int SLC_FRAMES = 72;

  // expected ESF pattern bits, bit k belongs to the k-th pattern frame
  localparam logic [5:0] ESF_PAT = 6'b110100;
  // expected superframe signaling bits, bit k belongs to odd index 2k+1
  localparam logic [4:0] SF_SIG_PAT = 5'b11100;

endpackage

// File: rtl/t1fc_expect.sv
module t1fc_expect
  import t1fc_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic [1:0]       mode,
  input  logic             fs_chk_en,
  input  logic [IDX_W-1:0] frame_idx,
  output logic             chk,
  output logic             exp_bit
);

  localparam int PIDX_W = (IDX_W > 2) ? IDX_W - 2 : 1;

  logic             is_even;
  logic [IDX_W-1:0] half_idx;
  logic [PIDX_W-1:0] quad_idx;
  logic             term_exp;

  always_comb begin
    is_even  = ~frame_idx[0];
    half_idx = frame_idx >> 1;
    quad_idx = PIDX_W'(frame_idx >> 2);
    term_exp = ~frame_idx[1];
    chk      = 1'b0;
    exp_bit  = 1'b0;
    case (fmode_e'(mode))
      FM_ESF: begin
        if ((int'(frame_idx) < ESF_FRAMES) && (frame_idx[1:0] == 2'b11)) begin
          chk     = 1'b1;
          exp_bit = ESF_PAT[quad_idx[2:0]];
        end
      end
      FM_SF: begin
        if (int'(frame_idx) < SF_FRAMES) begin
          if (is_even) begin
            chk     = 1'b1;
            exp_bit = term_exp;
          end else if (fs_chk_en && (int'(frame_idx) != SF_FRAMES - 1)) begin
            chk     = 1'b1;
            exp_bit = SF_SIG_PAT[half_idx[2:0]];
          end
        end
      end
      FM_SLC: begin
        if ((int'(frame_idx) < SLC_FRAMES) && is_even) begin
          chk     = 1'b1;
          exp_bit = term_exp;
        end
      end
      default: begin
        chk     = 1'b0;
        exp_bit = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/t1fc_err_cnt.sv
module t1fc_err_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      wrap <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= inc && (cnt == CNT_MAX);
      if (inc) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/t1_fbit_checker.sv
module t1_fbit_checker #(
  parameter int IDX_W = 7,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             fs_chk_en,
  input  logic             in_sync,
  input  logic             fbit_vld,
  input  logic             fbit,
  input  logic [IDX_W-1:0] frame_idx,
  input  logic             cnt_clr,
  input  logic             evt_irq_en,
  input  logic             ovf_irq_en,
  output logic             err_pulse,
  output logic [CNT_W-1:0] err_cnt,
  output logic             evt_irq,
  output logic             ovf_irq
);

  logic chk;
  logic exp_bit;
  logic err_now;
  logic wrap;
  logic ovf_en_q;

  t1fc_expect #(.IDX_W(IDX_W)) u_expect (
    .mode      (mode),
    .fs_chk_en (fs_chk_en),
    .frame_idx (frame_idx),
    .chk       (chk),
    .exp_bit   (exp_bit)
  );

  assign err_now = fbit_vld && in_sync && chk && (fbit != exp_bit);

  t1fc_err_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .inc  (err_now),
    .clr  (cnt_clr),
    .cnt  (err_cnt),
    .wrap (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse <= 1'b0;
      evt_irq   <= 1'b0;
      ovf_en_q  <= 1'b0;
    end else begin
      err_pulse <= err_now;
      evt_irq   <= err_now && evt_irq_en;
      ovf_en_q  <= ovf_irq_en;
    end
  end

  assign ovf_irq = wrap && ovf_en_q;

endmodule

// File: rtl/t1_fbit_checker_sva.sv
module t1_fbit_checker_sva #(
  parameter int IDX_W = 7,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic             fbit_vld,
  input logic             in_sync,
  input logic [IDX_W-1:0] frame_idx,
  input logic             cnt_clr,
  input logic             evt_irq_en,
  input logic             ovf_irq_en,
  input logic             err_pulse,
  input logic [CNT_W-1:0] err_cnt,
  input logic             evt_irq,
  input logic             ovf_irq
);

  p_pulse_after_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> ($past(fbit_vld) && $past(in_sync)));

  p_no_check_mode_r7: assert property (@(posedge clk) disable iff (rst)
    (fbit_vld && mode == 2'd3) |=> !err_pulse);

  p_esf_skip_r2: assert property (@(posedge clk) disable iff (rst)
    (fbit_vld && mode == 2'd0 && frame_idx[1:0] != 2'b11) |=> !err_pulse);

  p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
    (err_pulse && !$past(cnt_clr)) |-> (err_cnt == CNT_W'($past(err_cnt) + 1'b1)));

  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!err_pulse && !$past(cnt_clr)) |-> $stable(err_cnt));

  p_ovf_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> (err_pulse && err_cnt == '0));

  p_clr_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (err_cnt == '0 && !ovf_irq));

  p_evt_gate_r10: assert property (@(posedge clk) disable iff (rst)
    evt_irq |-> (err_pulse && $past(evt_irq_en)));

  p_ovf_gate_r10: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> $past(ovf_irq_en));

endmodule

bind t1_fbit_checker t1_fbit_checker_sva #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_sva (.*);

// File: tb/t1_fbit_checker_bench.sv
module t1_fbit_checker_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic       fs_chk_en = 1'b0;
  logic       in_sync = 1'b1;
  logic       fbit_vld = 1'b0;
  logic       fbit = 1'b0;
  logic [6:0] frame_idx = '0;
  logic       cnt_clr = 1'b0;
  logic       evt_irq_en = 1'b0;
  logic       ovf_irq_en = 1'b0;
  logic       err_pulse;
  logic [7:0] err_cnt;
  logic       evt_irq;
  logic       ovf_irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cnt_m = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  t1_fbit_checker u_t1_fbit_checker (
    .clk(clk), .rst(rst), .mode(mode), .fs_chk_en(fs_chk_en), .in_sync(in_sync),
    .fbit_vld(fbit_vld), .fbit(fbit), .frame_idx(frame_idx), .cnt_clr(cnt_clr),
    .evt_irq_en(evt_irq_en), .ovf_irq_en(ovf_irq_en), .err_pulse(err_pulse),
    .err_cnt(err_cnt), .evt_irq(evt_irq), .ovf_irq(ovf_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit ref_chk(input int m, input int ix, input bit fs);
    case (m)
      0: return (ix < 24) && (ix % 4 == 3);
      1: return (ix < 12) && ((ix % 2 == 0) || (fs && ix != 11));
      2: return (ix < 72) && (ix % 2 == 0);
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit ref_exp(input int m, input int ix);
    bit esf_p [6] = '{0, 0, 1, 0, 1, 1};
    bit sig_p [5] = '{0, 0, 1, 1, 1};
    if (m == 0) return esf_p[ix / 4];
    if (ix % 2 == 0) return ((ix / 2) % 2) == 0;
    return sig_p[ix / 2];
  endfunction

  task automatic send(input string req, input int m, input int ix, input bit fb);
    bit e;
    bit ovf_e;
    @(negedge clk);
    mode = 2'(m); frame_idx = 7'(ix); fbit = fb; fbit_vld = 1'b1;
    @(negedge clk);
    fbit_vld = 1'b0;
    e = in_sync && ref_chk(m, ix, fs_chk_en) && (fb != ref_exp(m, ix));
    ovf_e = 1'b0;
    if (cnt_clr) cnt_m = 0;
    else if (e) begin
      ovf_e = (cnt_m == 255);
      cnt_m = (cnt_m + 1) % 256;
    end
    check({req, " err_pulse"}, int'(err_pulse), int'(e));
    check("R8 err_cnt", int'(err_cnt), cnt_m);
    check("R10 evt_irq", int'(evt_irq), int'(e && evt_irq_en));
    check("R8 ovf_irq", int'(ovf_irq), int'(ovf_e && ovf_irq_en));
  endtask

  task automatic t_reset();
    check("R1 err_pulse", int'(err_pulse), 0);
    check("R1 err_cnt", int'(err_cnt), 0);
    check("R1 evt_irq", int'(evt_irq), 0);
    check("R1 ovf_irq", int'(ovf_irq), 0);
  endtask

  task automatic t_esf();
    for (int i = 0; i < 24; i++) begin
      send("R2", 0, i, 1'b0);
      send("R2", 0, i, 1'b1);
    end
  endtask

  task automatic t_sf();
    fs_chk_en = 1'b0;
    for (int i = 0; i < 12; i++) begin
      send("R3", 1, i, 1'b0);
      send("R3", 1, i, 1'b1);
    end
    fs_chk_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      send("R4", 1, i, 1'b0);
      send("R4", 1, i, 1'b1);
    end
    fs_chk_en = 1'b0;
  endtask

  task automatic t_slc();
    for (int i = 0; i < 72; i++) begin
      send("R5", 2, i, 1'b0);
      send("R5", 2, i, 1'b1);
    end
  endtask

  task automatic t_range();
    for (int i = 0; i < 4; i++) begin
      send("R7", 3, i, 1'b0);
      send("R7", 3, i, 1'b1);
    end
    send("R7", 0, 27, 1'b1);
    send("R7", 0, 31, 1'b0);
    fs_chk_en = 1'b1;
    send("R7", 1, 12, 1'b0);
    send("R7", 1, 13, 1'b1);
    fs_chk_en = 1'b0;
    send("R7", 2, 72, 1'b0);
    send("R7", 2, 76, 1'b0);
  endtask

  task automatic t_gate();
    in_sync = 1'b0;
    send("R6 no sync", 0, 3, 1'b1);
    send("R6 no sync", 1, 0, 1'b0);
    in_sync = 1'b1;
    @(negedge clk);
    mode = 2'd0; frame_idx = 7'd3; fbit = 1'b1; fbit_vld = 1'b0;
    @(negedge clk);
    check("R6 no strobe", int'(err_pulse), 0);
    send("R6", 0, 3, 1'b1);
    @(negedge clk);
    check("R6 single cycle", int'(err_pulse), 0);
  endtask

  task automatic t_count();
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0; cnt_m = 0;
    check("R9 cleared", int'(err_cnt), 0);
    evt_irq_en = 1'b1; ovf_irq_en = 1'b1;
    for (int k = 0; k < 256; k++) send("R8", 0, 3, 1'b1);
    check("R8 wrapped", int'(err_cnt), 0);
    evt_irq_en = 1'b0; ovf_irq_en = 1'b0;
    for (int k = 0; k < 256; k++) send("R10", 0, 7, 1'b1);
    check("R10 wrapped quiet", int'(err_cnt), 0);
  endtask

  task automatic t_clr();
    send("R9", 0, 11, 1'b0);
    send("R9", 0, 11, 1'b0);
    ovf_irq_en = 1'b1; evt_irq_en = 1'b1;
    cnt_clr = 1'b1;
    send("R9 clr held", 0, 11, 1'b0);
    send("R9 clr held", 0, 23, 1'b0);
    check("R9 count zero", int'(err_cnt), 0);
    cnt_clr = 1'b0;
    send("R9 after clr", 0, 15, 1'b1);
    check("R9 restart", int'(err_cnt), 1);
    ovf_irq_en = 1'b0; evt_irq_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_esf();
    t_sf();
    t_slc();
    t_range();
    t_gate();
    t_count();
    t_clr();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule